// File: doc/BRIEF.md
# Serial Flash Phased Transaction Sequencer

This block runs one serial NOR flash transaction at a time on a four-lane bidirectional pad group. The transaction is described by configuration inputs that a register bank elsewhere holds stable: opcodes, an address, up to four option bytes, a dummy-cycle length, and one enable and one lane-width code for each phase. A one-cycle start pulse launches the transaction. The block then runs the enabled phases back to back in a fixed order, sending or capturing data on one, two or four lanes, and sets a done flag at the end.

The serial clock is the system clock divided by the even ratio `CLK_DIV`. It idles low. Each serial beat spends its first half low and its second half high. Outputs change when the clock falls and inputs are captured when it rises. Chip select can stay asserted after a transaction. The next transaction can then run only a data phase, so a long transfer is built from chained pieces of at most four bytes.

Top module: `sflash_seq`

## Requirements
- R1: During and after reset, cs_n_o is 1, sck_o is 0, io_oe_o is 0, done_o is 0 and rdata_o is 0.
- R2: The enabled phases run in this order, and disabled phases are skipped: command opcode, second opcode, address, option bytes, dummy cycles, data. The serial clock rises exactly once per beat.
- R3: A lane code of 0 uses one lane, 1 uses two lanes, and 2 or 3 uses four lanes. Bits go out most significant first. In each beat the highest driven lane carries the earliest bit. Driven lanes have io_oe_o equal to 4'b0001, 4'b0011 or 4'b1111.
- R4: The number of address bytes is the number of set bits in addr_mask_i. Those bytes are the low bytes of addr_i, sent most significant first. A mask of 4'b0000 skips the address phase.
- R5: The option and data masks fill from the top byte (4'b1000 = 1 byte up to 4'b1111 = 4 bytes). Bytes are taken from bit 31 downward of opt_i or wdata_i, so a 1- or 2-byte write uses the upper half of wdata_i.
- R6: With dummy_en_i set, the dummy phase lasts dummy_len_i+1 beats and io_oe_o is 0 for its whole length.
- R7: A data phase runs only when data_mask_i is not zero and at least one of rd_en_i and wr_en_i is set. wr_en_i takes priority and selects a write. A read holds io_oe_o at 0 and samples io_in_i[1] for one lane, io_in_i[1:0] for two lanes, or io_in_i[3:0] for four lanes.
- R8: When a read completes, rdata_o holds the received bytes aligned to bit 31 with the lower bits zero. Transactions without a read leave rdata_o unchanged.
- R9: done_o is 0 on the clock edge after a start is accepted. It rises exactly B*CLK_DIV+1 edges after that start edge, where B is the total number of beats.
- R10: Each beat lasts CLK_DIV clocks, and io_out_o is stable while sck_o is high. sck_o is low whenever no phase is running.
- R11: cs_n_o goes low on the edge that accepts a start and stays low while phases run. At completion it goes high only if keep_sel_i is 0.
- R12: A start pulse that arrives while a transaction is running has no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch pulse |
| keep_sel_i | input | 1 | Hold chip select after completion |
| rd_en_i | input | 1 | Data phase reads |
| wr_en_i | input | 1 | Data phase writes (priority over read) |
| cmd_en_i | input | 1 | Enable command opcode phase |
| cmd_lane_i | input | 2 | Lane code of command phase |
| cmd_code_i | input | 8 | Command opcode |
| ocmd_en_i | input | 1 | Enable second opcode phase |
| ocmd_lane_i | input | 2 | Lane code of second opcode phase |
| ocmd_code_i | input | 8 | Second opcode |
| addr_mask_i | input | 4 | Address byte mask |
| addr_lane_i | input | 2 | Lane code of address phase |
| addr_i | input | 32 | Address |
| opt_mask_i | input | 4 | Option byte mask |
| opt_lane_i | input | 2 | Lane code of option phase |
| opt_i | input | 32 | Option bytes |
| dummy_en_i | input | 1 | Enable dummy phase |
| dummy_len_i | input | 5 | Dummy beats minus one |
| data_mask_i | input | 4 | Data byte mask |
| data_lane_i | input | 2 | Lane code of data phase |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, aligned to bit 31 |
| done_o | output | 1 | Completion flag |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| io_out_o | output | 4 | Lane output values |
| io_oe_o | output | 4 | Lane output enables |
| io_in_i | input | 4 | Lane input values |

## Verification
Serial results fall on serial clock edges, not on fixed clock counts. The bench therefore acts as the flash device: it records io_out_o, io_oe_o and cs_n_o on every rising edge of sck_o, and it sets io_in_i on the system clock falling edge before the rise that samples it. It compares the recorded beats with a beat list built from the configuration. Cycle-exact results are checked against exact counts. done_o must be low on the first falling edge after the start edge and must first read high exactly B*CLK_DIV+1 edges after it. Consecutive serial clock rises must be CLK_DIV cycles apart. cs_n_o and rdata_o are checked on the falling edge where done_o is first seen high, because they change on the same edge as done_o.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
    localparam int WORD_W  = 32;
    localparam int NBYTES  = WORD_W / 8;
    localparam int DUMMY_W = 5;
    localparam int BEAT_W  = $clog2(WORD_W + 1);
    localparam int LANES   = 4;
    localparam int NPHASE  = 6;

    typedef enum logic [2:0] {
        PH_IDLE, PH_CMD, PH_OCMD, PH_ADDR, PH_OPT, PH_DUMMY, PH_DATA, PH_FIN
    } phase_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [BEAT_W-1:0] beats;
        logic [1:0]        lg;
        logic              drive;
        logic              rx;
    } load_t;

    function automatic logic [1:0] lane_lg(logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    function automatic logic [2:0] byte_cnt(logic [3:0] m);
        return 3'(m[0]) + 3'(m[1]) + 3'(m[2]) + 3'(m[3]);
    endfunction

    function automatic logic [BEAT_W-1:0] beats_for(logic [2:0] nb, logic [1:0] lg);
        logic [5:0] bits;
        bits = {nb, 3'b000};
        return BEAT_W'(bits >> lg);
    endfunction

    function automatic logic [5:0] align_shift(logic [2:0] nb);
        return {3'(3'd4 - nb), 3'b000};
    endfunction

    function automatic logic [LANES-1:0] lane_mask(logic [1:0] lg);
        case (lg)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic phase_e next_phase(phase_e cur, logic [NPHASE-1:0] en);
        phase_e r;
        logic   hit;
        r   = PH_FIN;
        hit = 1'b0;
        for (int i = 0; i < NPHASE; i++) begin
            if (!hit && en[i] && (i + 1) > int'(cur)) begin
                r   = phase_e'(3'(i + 1));
                hit = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/sfq_sclk.sv
module sfq_sclk #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sck,
    output logic sample,
    output logic beat_end
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] PRE  = CW'(HALF - 1);
    localparam logic [CW-1:0] MID  = CW'(HALF);

    logic [CW-1:0] hc;

    always_ff @(posedge clk) begin
        if (rst || !run)   hc <= '0;
        else if (hc == LAST) hc <= '0;
        else               hc <= hc + 1'b1;
    end

    assign sck      = run && (hc >= MID);
    assign sample   = run && (hc == PRE);
    assign beat_end = run && (hc == LAST);

    // R10: a running beat counter wraps back to the low half
    assert_beat_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        beat_end |=> !sck)
        else $error("beat did not restart low");
endmodule

// File: rtl/sfq_shift.sv
module sfq_shift import sfq_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic [1:0]        lg,
    input  logic              shift,
    input  logic              sample,
    input  logic [LANES-1:0]  io_in,
    output logic [LANES-1:0]  tx_bits,
    output logic [WORD_W-1:0] rx_word
);
    logic [WORD_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            rx_word <= '0;
        end else begin
            if (load)       sr <= load_word;
            else if (shift) begin
                case (lg)
                    2'd0:    sr <= sr << 1;
                    2'd1:    sr <= sr << 2;
                    default: sr <= sr << 4;
                endcase
            end
            if (load)        rx_word <= '0;
            else if (sample) begin
                case (lg)
                    2'd0:    rx_word <= {rx_word[WORD_W-2:0], io_in[1]};
                    2'd1:    rx_word <= {rx_word[WORD_W-3:0], io_in[1:0]};
                    default: rx_word <= {rx_word[WORD_W-5:0], io_in};
                endcase
            end
        end
    end

    always_comb begin
        case (lg)
            2'd0:    tx_bits = {3'b000, sr[WORD_W-1]};
            2'd1:    tx_bits = {2'b00, sr[WORD_W-1 -: 2]};
            default: tx_bits = sr[WORD_W-1 -: 4];
        endcase
    end
endmodule

// File: rtl/sfq_ctrl.sv
module sfq_ctrl import sfq_pkg::*; (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               keep_sel,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic               cmd_en,
    input  logic [1:0]         cmd_lane,
    input  logic [7:0]         cmd_code,
    input  logic               ocmd_en,
    input  logic [1:0]         ocmd_lane,
    input  logic [7:0]         ocmd_code,
    input  logic [3:0]         addr_mask,
    input  logic [1:0]         addr_lane,
    input  logic [WORD_W-1:0]  addr,
    input  logic [3:0]         opt_mask,
    input  logic [1:0]         opt_lane,
    input  logic [WORD_W-1:0]  opt,
    input  logic               dummy_en,
    input  logic [DUMMY_W-1:0] dummy_len,
    input  logic [3:0]         data_mask,
    input  logic [1:0]         data_lane,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               beat_end,
    input  logic [WORD_W-1:0]  rx_word,
    output logic               running,
    output logic               load,
    output logic [WORD_W-1:0]  load_word,
    output logic               shift,
    output logic [1:0]         cur_lg,
    output logic               cur_drive,
    output logic               cs_n,
    output logic               done,
    output logic [WORD_W-1:0]  rdata
);
    phase_e             phase, nxt;
    load_t              ld;
    logic [BEAT_W-1:0]  left;
    logic [NPHASE-1:0]  en;
    logic               last, advance, accept, rd_seen;
    logic [1:0]         g;
    logic [2:0]         nb;

    assign en = {(rd_en || wr_en) && (data_mask != 4'd0), dummy_en,
                 opt_mask != 4'd0, addr_mask != 4'd0, ocmd_en, cmd_en};

    assign running = (phase != PH_IDLE) && (phase != PH_FIN);
    assign accept  = (phase == PH_IDLE) && start;
    assign last    = running && beat_end && (left == BEAT_W'(1));
    assign advance = accept || last;
    assign nxt     = next_phase(phase, en);
    assign load    = advance && (nxt != PH_FIN);
    assign shift   = beat_end && !load;
    assign load_word = ld.word;

    always_comb begin
        ld = '0;
        g  = 2'd0;
        nb = 3'd0;
        case (nxt)
            PH_CMD:  begin g = lane_lg(cmd_lane);  nb = 3'd1; ld.word = {cmd_code, 24'd0}; end
            PH_OCMD: begin g = lane_lg(ocmd_lane); nb = 3'd1; ld.word = {ocmd_code, 24'd0}; end
            PH_ADDR: begin
                g = lane_lg(addr_lane);
                nb = byte_cnt(addr_mask);
                ld.word = addr << align_shift(nb);
            end
            PH_OPT:  begin g = lane_lg(opt_lane);  nb = byte_cnt(opt_mask); ld.word = opt; end
            PH_DATA: begin
                g = lane_lg(data_lane);
                nb = byte_cnt(data_mask);
                ld.word = wr_en ? wdata : '0;
            end
            default: ;
        endcase
        ld.lg    = g;
        ld.beats = beats_for(nb, g);
        ld.drive = (nxt != PH_DUMMY) && (nxt != PH_FIN) && !(nxt == PH_DATA && !wr_en);
        ld.rx    = (nxt == PH_DATA) && !wr_en;
        if (nxt == PH_DUMMY) ld.beats = BEAT_W'(dummy_len) + BEAT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            left      <= '0;
            cur_lg    <= 2'd0;
            cur_drive <= 1'b0;
            rd_seen   <= 1'b0;
            cs_n      <= 1'b1;
            done      <= 1'b0;
            rdata     <= '0;
        end else begin
            if (advance) begin
                phase     <= nxt;
                left      <= ld.beats;
                cur_lg    <= ld.lg;
                cur_drive <= ld.drive;
                if (ld.rx) rd_seen <= 1'b1;
            end else if (running && beat_end) begin
                left <= left - BEAT_W'(1);
            end
            if (accept) begin
                done <= 1'b0;
                cs_n <= 1'b0;
                if (!ld.rx) rd_seen <= 1'b0;
            end
            if (phase == PH_FIN) begin
                phase   <= PH_IDLE;
                done    <= 1'b1;
                cs_n    <= !keep_sel;
                rd_seen <= 1'b0;
                if (rd_seen) rdata <= rx_word << align_shift(byte_cnt(data_mask));
            end
        end
    end

    // R11: chip select is held low while any phase runs
    assert_cs_busy_R11: assert property (@(posedge clk) disable iff (rst)
        running |-> !cs_n)
        else $error("chip select released mid transaction");

    // R9: an accepted start clears the done flag on the next edge
    assert_done_clear_R9: assert property (@(posedge clk) disable iff (rst)
        accept |=> !done)
        else $error("done not cleared after start");

    // R2: phase changes only move forward in the fixed order
    assert_phase_order_R2: assert property (@(posedge clk) disable iff (rst)
        advance |=> (phase > $past(phase)))
        else $error("phase order broken");

    // R12: a start during a running phase leaves the phase in place
    assert_busy_start_R12: assert property (@(posedge clk) disable iff (rst)
        (running && start && !beat_end) |=> $stable(phase))
        else $error("start disturbed a running transaction");
endmodule

// File: rtl/sflash_seq.sv
module sflash_seq import sfq_pkg::*; #(
    parameter int CLK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               keep_sel_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic               cmd_en_i,
    input  logic [1:0]         cmd_lane_i,
    input  logic [7:0]         cmd_code_i,
    input  logic               ocmd_en_i,
    input  logic [1:0]         ocmd_lane_i,
    input  logic [7:0]         ocmd_code_i,
    input  logic [3:0]         addr_mask_i,
    input  logic [1:0]         addr_lane_i,
    input  logic [WORD_W-1:0]  addr_i,
    input  logic [3:0]         opt_mask_i,
    input  logic [1:0]         opt_lane_i,
    input  logic [WORD_W-1:0]  opt_i,
    input  logic               dummy_en_i,
    input  logic [DUMMY_W-1:0] dummy_len_i,
    input  logic [3:0]         data_mask_i,
    input  logic [1:0]         data_lane_i,
    input  logic [WORD_W-1:0]  wdata_i,
    output logic [WORD_W-1:0]  rdata_o,
    output logic               done_o,
    output logic               cs_n_o,
    output logic               sck_o,
    output logic [LANES-1:0]   io_out_o,
    output logic [LANES-1:0]   io_oe_o,
    input  logic [LANES-1:0]   io_in_i
);
    logic              running, load, shift, sample, beat_end, cur_drive;
    logic [WORD_W-1:0] load_word, rx_word;
    logic [1:0]        cur_lg;

    sfq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start_i), .keep_sel(keep_sel_i),
        .rd_en(rd_en_i), .wr_en(wr_en_i),
        .cmd_en(cmd_en_i), .cmd_lane(cmd_lane_i), .cmd_code(cmd_code_i),
        .ocmd_en(ocmd_en_i), .ocmd_lane(ocmd_lane_i), .ocmd_code(ocmd_code_i),
        .addr_mask(addr_mask_i), .addr_lane(addr_lane_i), .addr(addr_i),
        .opt_mask(opt_mask_i), .opt_lane(opt_lane_i), .opt(opt_i),
        .dummy_en(dummy_en_i), .dummy_len(dummy_len_i),
        .data_mask(data_mask_i), .data_lane(data_lane_i), .wdata(wdata_i),
        .beat_end(beat_end), .rx_word(rx_word),
        .running(running), .load(load), .load_word(load_word), .shift(shift),
        .cur_lg(cur_lg), .cur_drive(cur_drive),
        .cs_n(cs_n_o), .done(done_o), .rdata(rdata_o)
    );

    sfq_sclk #(.DIV(CLK_DIV)) u_sclk (
        .clk(clk), .rst(rst), .run(running),
        .sck(sck_o), .sample(sample), .beat_end(beat_end)
    );

    sfq_shift u_shift (
        .clk(clk), .rst(rst), .load(load), .load_word(load_word), .lg(cur_lg),
        .shift(shift), .sample(sample), .io_in(io_in_i),
        .tx_bits(io_out_o), .rx_word(rx_word)
    );

    assign io_oe_o = cur_drive ? lane_mask(cur_lg) : '0;

    // R10: lane values hold while the serial clock is high
    assert_io_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (sck_o && $past(sck_o)) |-> $stable(io_out_o))
        else $error("lane output moved while clock high");

    // R3: only the legal lane groups are ever driven
    assert_lane_group_R3: assert property (@(posedge clk) disable iff (rst)
        (io_oe_o == 4'b0000) || (io_oe_o == 4'b0001) || (io_oe_o == 4'b0011) || (io_oe_o == 4'b1111))
        else $error("illegal lane enable group");
endmodule

// File: tb/sflash_seq_bench.sv
`timescale 1ns/1ps
module sflash_seq_bench;
    localparam int DIV = 4;

    logic        clk = 1'b0, rst = 1'b1;
    logic        start = 0, keep = 0, rd_en = 0, wr_en = 0;
    logic        cmd_en = 0, ocmd_en = 0, dummy_en = 0;
    logic [1:0]  cmd_lane = 0, ocmd_lane = 0, addr_lane = 0, opt_lane = 0, data_lane = 0;
    logic [7:0]  cmd_code = 0, ocmd_code = 0;
    logic [3:0]  addr_mask = 0, opt_mask = 0, data_mask = 0;
    logic [31:0] addr = 0, opt = 0, wdata = 0;
    logic [4:0]  dummy_len = 0;
    logic [31:0] rdata;
    logic        done, cs_n, sck;
    logic [3:0]  io_out, io_oe, io_in = 0;

    sflash_seq #(.CLK_DIV(DIV)) u_sflash_seq (
        .clk(clk), .rst(rst), .start_i(start), .keep_sel_i(keep),
        .rd_en_i(rd_en), .wr_en_i(wr_en),
        .cmd_en_i(cmd_en), .cmd_lane_i(cmd_lane), .cmd_code_i(cmd_code),
        .ocmd_en_i(ocmd_en), .ocmd_lane_i(ocmd_lane), .ocmd_code_i(ocmd_code),
        .addr_mask_i(addr_mask), .addr_lane_i(addr_lane), .addr_i(addr),
        .opt_mask_i(opt_mask), .opt_lane_i(opt_lane), .opt_i(opt),
        .dummy_en_i(dummy_en), .dummy_len_i(dummy_len),
        .data_mask_i(data_mask), .data_lane_i(data_lane), .wdata_i(wdata),
        .rdata_o(rdata), .done_o(done), .cs_n_o(cs_n), .sck_o(sck),
        .io_out_o(io_out), .io_oe_o(io_oe), .io_in_i(io_in)
    );

    always #10 clk = ~clk;

    int errors = 0, checks = 0, cyc = 0;
    int rise_cnt = 0, rise_base = 0, nexp = 0;
    logic [3:0]  e_out [256];
    logic [3:0]  e_oe  [256];
    logic [3:0]  e_in  [256];
    logic        e_chk [256];
    string       e_tag [256];
    logic [3:0]  o_out [256];
    logic [3:0]  o_oe  [256];
    logic        o_cs  [256];
    int          o_time[256];
    logic [31:0] exp_rdata = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog R9: cycles=%0d expected below 190000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    always @(posedge sck) begin
        int i;
        i = rise_cnt - rise_base;
        if (i >= 0 && i < 256) begin
            o_out[i] = io_out; o_oe[i] = io_oe; o_cs[i] = cs_n; o_time[i] = cyc;
        end
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge clk) begin
        int i;
        i = rise_cnt - rise_base;
        io_in = (i >= 0 && i < 256) ? e_in[i] : 4'd0;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic int wd(input logic [1:0] code);
        return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
    endfunction

    task automatic push_tx(input logic [31:0] w, input int nbytes, input logic [1:0] code, input string tag);
        int n = wd(code);
        for (int k = 0; k < nbytes * 8 / n; k++) begin
            logic [31:0] t;
            t = (w >> (32 - (k + 1) * n)) & ((32'd1 << n) - 1);
            e_out[nexp] = t[3:0]; e_oe[nexp] = 4'((32'd1 << n) - 1);
            e_in[nexp] = 4'($urandom); e_chk[nexp] = 1'b1; e_tag[nexp] = tag;
            nexp++;
        end
    endtask

    task automatic push_rx(input logic [31:0] w, input int nbytes, input logic [1:0] code);
        int n = wd(code);
        for (int k = 0; k < nbytes * 8 / n; k++) begin
            logic [31:0] t;
            logic [3:0]  v;
            t = w >> (32 - (k + 1) * n);
            v = 4'($urandom);
            if (n == 1) v[1] = t[0];
            else if (n == 2) v[1:0] = t[1:0];
            else v = t[3:0];
            e_out[nexp] = 0; e_oe[nexp] = 0; e_in[nexp] = v; e_chk[nexp] = 1'b0;
            e_tag[nexp] = "R7"; nexp++;
        end
    endtask

    task automatic build_expect(input logic [31:0] rresp);
        int na, nd;
        nexp = 0;
        if (cmd_en)  push_tx({cmd_code, 24'd0}, 1, cmd_lane, "R2");
        if (ocmd_en) push_tx({ocmd_code, 24'd0}, 1, ocmd_lane, "R2");
        na = $countones(addr_mask);
        if (na > 0) push_tx(addr << (32 - 8 * na), na, addr_lane, "R4");
        if (opt_mask != 0) push_tx(opt, $countones(opt_mask), opt_lane, "R5");
        if (dummy_en) begin
            for (int k = 0; k <= int'(dummy_len); k++) begin
                e_out[nexp] = 0; e_oe[nexp] = 0; e_in[nexp] = 4'($urandom);
                e_chk[nexp] = 1'b0; e_tag[nexp] = "R6"; nexp++;
            end
        end
        nd = $countones(data_mask);
        if (nd > 0 && wr_en) push_tx(wdata, nd, data_lane, "R5");
        else if (nd > 0 && rd_en) begin
            push_rx(rresp, nd, data_lane);
            exp_rdata = rresp & (32'hFFFF_FFFF << (32 - 8 * nd));
        end
    endtask

    task automatic run_txn(input bit inject);
        int k, bad;
        string tag;
        logic [31:0] rresp;
        @(negedge clk);
        rise_base = rise_cnt;
        rresp = $urandom;
        build_expect(rresp);
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        k = 0;
        check(done == 1'b0, "R9 done cleared", 32'(done), 0);
        while (!done && k < 4000) begin
            @(negedge clk);
            k++;
            start = (inject && k == 3 && nexp * DIV + 1 > 5) ? 1'b1 : 1'b0;
        end
        start = 0;
        check(k == nexp * DIV + 1, "R9 done latency", 32'(k), 32'(nexp * DIV + 1));
        check(rise_cnt - rise_base == nexp, inject ? "R12 beat count" : "R2 beat count",
              32'(rise_cnt - rise_base), 32'(nexp));
        bad = 0; tag = "R3";
        for (int i = 0; i < nexp && i < 256; i++) begin
            if (bad == 0 && (o_oe[i] != e_oe[i] ||
                (e_chk[i] && ((o_out[i] & e_oe[i]) != e_out[i])))) begin
                bad = 1; tag = e_tag[i];
                $display("FAIL %s R3 beat %0d: actual out=%0h oe=%0h expected out=%0h oe=%0h",
                         tag, i, o_out[i], o_oe[i], e_out[i], e_oe[i]);
            end
        end
        checks++; if (bad != 0) errors++;
        bad = 0;
        for (int i = 1; i < nexp && i < 256; i++)
            if (o_time[i] - o_time[i-1] != DIV) bad++;
        check(bad == 0, "R10 beat period", 32'(bad), 0);
        bad = 0;
        for (int i = 0; i < nexp && i < 256; i++) if (o_cs[i]) bad++;
        check(bad == 0, "R11 select during beats", 32'(bad), 0);
        check(cs_n == !keep, "R11 select after done", 32'(cs_n), 32'(!keep));
        check(sck == 0 && io_oe == 0, "R10 idle lines", {30'd0, sck, |io_oe}, 0);
        check(rdata == exp_rdata, "R8 read data", rdata, exp_rdata);
    endtask

    task automatic clear_cfg();
        keep = 0; rd_en = 0; wr_en = 0; cmd_en = 0; ocmd_en = 0; dummy_en = 0;
        addr_mask = 0; opt_mask = 0; data_mask = 0;
        cmd_lane = 0; ocmd_lane = 0; addr_lane = 0; opt_lane = 0; data_lane = 0;
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (5) @(negedge clk);
        check(cs_n == 1 && sck == 0 && io_oe == 0 && done == 0 && rdata == 0,
              "R1 reset state", {cs_n, sck, io_oe, done}, 32'b1_0_0000_0);
        rst = 0;
        @(negedge clk);
        check(cs_n == 1 && sck == 0 && done == 0, "R1 after reset", {cs_n, sck, done}, 3'b100);

        // quad read: command, 3 address bytes, dummy, 4 data bytes (R4 R6 R7 R8)
        clear_cfg(); cmd_en = 1; cmd_code = 8'hEB; addr_mask = 4'b0111; addr_lane = 2;
        addr = 32'h12AB_CDEF; dummy_en = 1; dummy_len = 5; rd_en = 1; data_mask = 4'b1111; data_lane = 2;
        run_txn(0);
        // no phases at all: done one edge after start (R9)
        clear_cfg(); run_txn(0);
        // no direction: data mask ignored, no data phase (R7)
        clear_cfg(); cmd_en = 1; cmd_code = 8'h06; data_mask = 4'b1111; run_txn(0);
        // two-byte write from the upper half, lane code 3 as four lanes (R5 R3)
        clear_cfg(); cmd_en = 1; cmd_code = 8'h32; wr_en = 1; data_mask = 4'b1100; data_lane = 3;
        wdata = 32'hBEEF_0000; run_txn(0);
        // chained transfer holding select (R11), then data only
        clear_cfg(); keep = 1; cmd_en = 1; cmd_code = 8'h02; addr_mask = 4'b1111; addr = 32'h0000_1000;
        wr_en = 1; data_mask = 4'b1111; wdata = 32'h0102_0304; run_txn(0);
        clear_cfg(); wr_en = 1; data_mask = 4'b1110; data_lane = 1; wdata = 32'hA5C3_9900; run_txn(0);
        // dual read of one byte chained by select hold, then start while busy (R12)
        clear_cfg(); keep = 1; ocmd_en = 1; ocmd_code = 8'h5A; opt_mask = 4'b1000; opt = 32'h7F00_0000;
        rd_en = 1; data_mask = 4'b1000; data_lane = 1; run_txn(1);
        clear_cfg(); rd_en = 1; data_mask = 4'b1100; run_txn(1);

        for (int t = 0; t < 40; t++) begin
            int r;
            clear_cfg();
            keep = 1'($urandom); cmd_en = 1'($urandom); ocmd_en = 1'($urandom);
            cmd_lane = 2'($urandom); ocmd_lane = 2'($urandom); addr_lane = 2'($urandom);
            opt_lane = 2'($urandom); data_lane = 2'($urandom);
            cmd_code = 8'($urandom); ocmd_code = 8'($urandom);
            addr_mask = 4'($urandom); addr = $urandom; opt = $urandom; wdata = $urandom;
            opt_mask = 4'(4'hF << (4 - ($urandom % 5)));
            data_mask = 4'(4'hF << (4 - ($urandom % 5)));
            dummy_en = 1'($urandom); dummy_len = 5'($urandom);
            r = $urandom % 4; rd_en = (r == 1 || r == 3); wr_en = (r >= 2);
            run_txn(t % 5 == 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule